// File: doc/BRIEF.md
# Maskable Interrupt Pin Controller

This block gathers a vector of status signals from neighbouring functional units and turns their changes into interrupt pins toward a host processor. Any transition, rising or falling, on a status input sets a sticky pending bit. The host reads the pending bits and acknowledges them by writing ones back. Each output pin has its own enable mask over the pending bits, so each pin can be routed a different subset of events.

There are three outputs. The two push-pull pins each have a programmable active level. Either of them can instead be switched to pass an audio-mute signal from the audio path. The third output models an open-drain line: it is a single output-enable that pulls the line low while an enabled event is pending. The host side is a plain single-cycle register port: a write strobe, an address and write data, with read data returned combinationally for the current address.

Register map (3-bit address). Address 3'd0 holds the pending bits: reads return them, and a write clears each bit written as 1. Addresses 3'd1, 3'd2 and 3'd3 hold the enable masks of pins 0, 1 and 2. Address 3'd4 is the pin configuration: bit 0 sets the active level of pin 0 and bit 1 that of pin 1 (1 means active high, 0 means active low), bit 2 switches pin 0 to mute mode, and bit 3 does the same for pin 1. Addresses 3'd5 to 3'd7 are unused.

Top module: `irq_pin_ctrl`

## Requirements
- R1: A rising or a falling transition on any status input, compared with the value sampled on the previous clock, sets that input's pending bit at the same edge. The bit is readable at address 3'd0 after that edge.
- R2: A write to address 3'd0 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: If a status transition and a clear of the same bit fall on the same edge, the bit ends up set.
- R4: A pin is active while at least one pending bit that is also set in that pin's mask is pending. With an all-zero mask, no event affects the pin.
- R5: Config bit 0 (pin 0) and bit 1 (pin 1) select the active level: 1 drives the pin high when active, and 0 drives it low when active (idle high).
- R6: While config bit 2 (pin 0) or bit 3 (pin 1) is 1, that pin carries the audio-mute input, delayed by one clock, and ignores interrupts and polarity.
- R7: The third output is an open-drain enable. It is 1 (drive low) while an event enabled in mask 3'd3 is pending, and 0 (released) otherwise.
- R8: All pin outputs are registered. A pending-bit change shows on a pin one clock after the pending bit itself changes.
- R9: After reset, all pending bits, masks and config are zero, pins 0 and 1 are high, and the open-drain enable is 0.
- R10: Masks and config read back what was written. Addresses 3'd5 to 3'd7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | EVT_W | Status inputs watched for transitions |
| audio_mute_i | input | 1 | Audio-mute level for pins in mute mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | EVT_W | Register write data |
| reg_rdata_o | output | EVT_W | Read data for reg_addr_i |
| irq0_o | output | 1 | Interrupt or mute pin 0 |
| irq1_o | output | 1 | Interrupt or mute pin 1 |
| irq2_oe_o | output | 1 | Open-drain enable of the third interrupt line |

## Verification
A status transition applied before rising edge k is in the pending register at edge k. It is therefore visible at read address 3'd0 just after that edge, and on a masked pin one edge later, at k+1. A mute level reaches its pin one edge after it is applied, and mask and config writes are readable immediately after the writing edge. The bench drives inputs on falling edges and advances a behavioural model at each rising edge. It compares every output at the following falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W   = 3;
    localparam int NUM_PINS = 3;
    localparam int CFG_W    = 4;
    localparam int CFG_POL_LSB  = 0;
    localparam int CFG_MUTE_LSB = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_PENDING = 3'd0,
        RA_MASK0   = 3'd1,
        RA_MASK1   = 3'd2,
        RA_MASK2   = 3'd3,
        RA_CFG     = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] status_i,
    input  logic [EVT_W-1:0] clr_i,
    output logic [EVT_W-1:0] pend_o
);
    logic [EVT_W-1:0] prev_q;
    logic [EVT_W-1:0] pend_q;
    logic [EVT_W-1:0] chg;

    assign chg = status_i ^ prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= status_i;
            pend_q <= (pend_q & ~clr_i) | chg;
        end
    end

    assign pend_o = pend_q;

    // R1: every changed bit is pending after the edge
    assert_set_on_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((pend_q & $past(chg)) == $past(chg)));
    // R3: a clear colliding with a change leaves the bit set
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg & clr_i) != '0) |=> ((pend_q & $past(chg & clr_i)) == $past(chg & clr_i)));
    // R2: a clear without a change empties the bit
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~chg) != '0) |=> ((pend_q & $past(clr_i & ~chg)) == '0));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int EVT_W = 8   // must be at least CFG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [EVT_W-1:0]    wdata_i,
    input  logic [EVT_W-1:0]    pend_i,
    output logic [EVT_W-1:0]    mask_o [NUM_PINS],
    output logic [CFG_W-1:0]    cfg_o,
    output logic [EVT_W-1:0]    clr_o,
    output logic [EVT_W-1:0]    rdata_o
);
    logic [EVT_W-1:0] mask_q [NUM_PINS];
    logic [CFG_W-1:0] cfg_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(RA_MASK0) + p);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[p] <= '0;
            end else if (wr_en_i && addr_i == MY_ADDR) begin
                mask_q[p] <= wdata_i;
            end
        end
        assign mask_o[p] = mask_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && addr_i == RA_CFG) begin
            cfg_q <= wdata_i[CFG_W-1:0];
        end
    end

    assign cfg_o = cfg_q;
    assign clr_o = (wr_en_i && addr_i == RA_PENDING) ? wdata_i : '0;

    always_comb begin
        rdata_o = '0;
        if (addr_i == RA_PENDING) begin
            rdata_o = pend_i;
        end else if (addr_i == RA_CFG) begin
            rdata_o[CFG_W-1:0] = cfg_q;
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr_i == ADDR_W'(int'(RA_MASK0) + p)) begin
                rdata_o = mask_q[p];
            end
        end
    end

    // R10: config is stable unless written at its own address
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == RA_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
    parameter int   EVT_W      = 8,
    parameter logic OPEN_DRAIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] pend_i,
    input  logic [EVT_W-1:0] mask_i,
    input  logic             act_high_i,
    input  logic             mute_sel_i,
    input  logic             mute_i,
    output logic             pin_o
);
    logic hit;
    logic pin_q;

    assign hit   = |(pend_i & mask_i);
    assign pin_o = pin_q;

    if (OPEN_DRAIN) begin : g_od
        logic unused_od;
        assign unused_od = ^{act_high_i, mute_sel_i, mute_i};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= hit;
        end

        // R7: the pull-down follows an enabled pending event one clock later
        assert_od_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> pin_o);
        assert_od_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !hit |=> !pin_o);
    end else begin : g_pp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pin_q <= 1'b1;
            else if (mute_sel_i) pin_q <= mute_i;
            else                 pin_q <= act_high_i ? hit : ~hit;
        end

        // R6: mute mode passes the mute level through one register
        assert_mute_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
            mute_sel_i |=> (pin_o == $past(mute_i)));
        // R5: an active-low pin sits high with nothing enabled pending
        assert_idle_low_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!mute_sel_i && !act_high_i && !hit) |=> pin_o);
    end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  status_i,
    input  logic              audio_mute_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [EVT_W-1:0]  reg_wdata_i,
    output logic [EVT_W-1:0]  reg_rdata_o,
    output logic              irq0_o,
    output logic              irq1_o,
    output logic              irq2_oe_o
);
    logic [EVT_W-1:0]    pend;
    logic [EVT_W-1:0]    clr;
    logic [EVT_W-1:0]    mask [NUM_PINS];
    logic [CFG_W-1:0]    cfg;
    logic [NUM_PINS-1:0] pin;

    irq_edge_latch #(.EVT_W(EVT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_i),
        .clr_i    (clr),
        .pend_o   (pend)
    );

    irq_regfile #(.EVT_W(EVT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend),
        .mask_o  (mask),
        .cfg_o   (cfg),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (p == NUM_PINS - 1) begin : g_od
            irq_pin_drive #(.EVT_W(EVT_W), .OPEN_DRAIN(1'b1)) u_drv (
                .clk        (clk),
                .rst_n      (rst_n),
                .pend_i     (pend),
                .mask_i     (mask[p]),
                .act_high_i (1'b0),
                .mute_sel_i (1'b0),
                .mute_i     (1'b0),
                .pin_o      (pin[p])
            );
        end else begin : g_pp
            irq_pin_drive #(.EVT_W(EVT_W), .OPEN_DRAIN(1'b0)) u_drv (
                .clk        (clk),
                .rst_n      (rst_n),
                .pend_i     (pend),
                .mask_i     (mask[p]),
                .act_high_i (cfg[CFG_POL_LSB + p]),
                .mute_sel_i (cfg[CFG_MUTE_LSB + p]),
                .mute_i     (audio_mute_i),
                .pin_o      (pin[p])
            );
        end
    end

    assign irq0_o    = pin[0];
    assign irq1_o    = pin[1];
    assign irq2_oe_o = pin[2];

    // R4: with every mask empty, the open-drain line stays released
    assert_mask_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[2] == '0) |=> !irq2_oe_o);
endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] status;
    logic         mute;
    logic         wr;
    logic [2:0]   addr;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic         irq0, irq1, irq2;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    irq_pin_ctrl #(.EVT_W(W)) u_irq_pin_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .status_i     (status),
        .audio_mute_i (mute),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq0_o       (irq0),
        .irq1_o       (irq1),
        .irq2_oe_o    (irq2)
    );

    // behavioural reference state
    logic [W-1:0] m_prev, m_pend;
    logic [W-1:0] m_mask [3];
    logic [3:0]   m_cfg;
    logic         m_p0, m_p1, m_oe;

    function automatic logic [W-1:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_pend;
            3'd1: return m_mask[0];
            3'd2: return m_mask[1];
            3'd3: return m_mask[2];
            3'd4: return {{(W-4){1'b0}}, m_cfg};
            default: return '0;
        endcase
    endfunction

    task automatic model_step();
        logic [W-1:0] clrv;
        if (!rst_n) begin
            m_prev = '0; m_pend = '0; m_cfg = '0;
            foreach (m_mask[i]) m_mask[i] = '0;
            m_p0 = 1'b1; m_p1 = 1'b1; m_oe = 1'b0;
            return;
        end
        m_p0 = m_cfg[2] ? mute : (m_cfg[0] ? (|(m_pend & m_mask[0])) : !(|(m_pend & m_mask[0])));
        m_p1 = m_cfg[3] ? mute : (m_cfg[1] ? (|(m_pend & m_mask[1])) : !(|(m_pend & m_mask[1])));
        m_oe = |(m_pend & m_mask[2]);
        clrv = (wr && addr == 3'd0) ? wdata : '0;
        m_pend = (m_pend & ~clrv) | (status ^ m_prev);
        m_prev = status;
        if (wr) begin
            if (addr == 3'd1) m_mask[0] = wdata;
            if (addr == 3'd2) m_mask[1] = wdata;
            if (addr == 3'd3) m_mask[2] = wdata;
            if (addr == 3'd4) m_cfg = wdata[3:0];
        end
    endtask

    task automatic cmp1(string tag, string what, logic got, logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic check();
        string rtag;
        string ptag;
        rtag = !rst_n ? "R9" : ((addr == 3'd0) ? "R1/R2/R3" : "R10");
        ptag = !rst_n ? "R9" : "R4/R5/R6/R8";
        vectors++;
        if (rdata !== m_read(addr)) begin
            miscompares++;
            $display("FAIL %s rdata@%0d got %h expected %h", rtag, addr, rdata, m_read(addr));
        end
        cmp1(ptag, "irq0", irq0, m_p0);
        cmp1(ptag, "irq1", irq1, m_p1);
        cmp1(!rst_n ? "R9" : "R7", "irq2_oe", irq2, m_oe);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check();
    endtask

    task automatic wr_reg(logic [2:0] a, logic [W-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0; wdata = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; status = '0; mute = 1'b0; wr = 1'b0; addr = 3'd4; wdata = '0;
        // R9: reset state, read over every address
        for (int i = 0; i < 5; i++) begin
            addr = 3'(i);
            cyc();
        end
        rst_n = 1'b1;
        addr = 3'd0;
        cyc();
        // R1: rising edges then a falling edge set pending bits
        status = 8'h05; cyc(); cyc();
        status = 8'h04; cyc(); cyc();
        // R2: clear bit 0 only, then a zero write leaves bits unchanged
        wr_reg(3'd0, 8'h01); addr = 3'd0; cyc();
        wr_reg(3'd0, 8'h00); addr = 3'd0; cyc();
        // R4 / R8: enable bit 2 on pin 0 (active low), watch it a cycle later
        wr_reg(3'd1, 8'h04); addr = 3'd1; cyc(); cyc();
        // R5: switch pin 0 to active high, pin 1 stays active low with empty mask
        wr_reg(3'd4, 8'h01); addr = 3'd4; cyc(); cyc();
        // R3: change bit 1 while clearing it in the same cycle
        status = 8'h06; wr_reg(3'd0, 8'h02); addr = 3'd0; cyc(); cyc();
        // R7: route bit 1 to the open-drain line, then clear it
        wr_reg(3'd3, 8'h02); cyc(); cyc();
        wr_reg(3'd0, 8'h02); cyc(); cyc();
        // R6: pin 1 in mute mode follows mute with one cycle delay
        wr_reg(3'd2, 8'hFF); cyc();
        wr_reg(3'd4, 8'h09);
        mute = 1'b1; cyc(); cyc();
        mute = 1'b0; cyc(); cyc();
        status = 8'hF0; cyc(); cyc();
        // R10: unused addresses ignore writes and read zero
        wr_reg(3'd5, 8'hAA); wr_reg(3'd6, 8'h55); wr_reg(3'd7, 8'hFF);
        for (int i = 5; i < 8; i++) begin
            addr = 3'(i);
            cyc();
        end
        for (int i = 1; i < 5; i++) begin
            addr = 3'(i);
            cyc();
        end
        // mixed traffic over all registers and inputs
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) status = status ^ W'($urandom);
            mute = 1'($urandom);
            wr = (($urandom % 3) == 0);
            addr = 3'($urandom);
            wdata = W'($urandom);
            cyc();
        end
        wr = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule